// File: doc/BRIEF.md
# Instruction-Driven Control Timing Unit

This block is the timing and control core of a small 16-bit accumulator processor. It holds the current instruction word and turns its three opcode bits into eight one-hot opcode lines. It also runs a free-stepping 4-bit sequence counter and turns the count into sixteen one-hot time-slot lines. The instruction's top bit is brought out as the indirect flag.

From the opcode lines, the indirect flag, the interrupt flag and the time slots, the block forms three controls for a 12-bit address register that lives inside the block: load, clear and increment. A load takes its value from one of three sources, and the active time slot picks the source: the program counter, the address field of the instruction, or memory data. Surrounding logic steps the processor through fetch, decode and execute by watching the time-slot lines. It restarts the counter with a synchronous clear input.

Top module: `ctl_timing_unit`

## Requirements
- R1: With `rst_n` low at a rising edge, the instruction register, the sequence counter and the address register all become zero. After reset, `time_lines` is 16'h0001 and `opcode_lines` is 8'h01.
- R2: When `ir_load` is high at a rising edge, `ir_q` takes `ir_data_in`. When it is low, `ir_q` keeps its value.
- R3: `opcode_lines` has bit k set for k = `ir_q[14:12]` and no other bit set. `ind_bit` equals `ir_q[15]`.
- R4: When `sc_clear` is low, the sequence counter advances by one on each rising edge and wraps from 15 to 0. `time_lines` has exactly the bit with the count's index set.
- R5: When `sc_clear` is high at a rising edge, the counter goes to 0, so `time_lines` is 16'h0001 on the next cycle.
- R6: When `intr_flag` is low and slot 0 is active, `ar_load` is high and the address register takes `pc_in`.
- R7: When `intr_flag` is low and slot 2 is active, `ar_load` is high and the address register takes `ir_q[11:0]`.
- R8: When the opcode is not 7, `ind_bit` is 1 and slot 3 is active, `ar_load` is high and the address register takes `mem_data_in`.
- R9: When `intr_flag` is high and slot 0 is active, `ar_clear` is high and the address register becomes zero.
- R10: When the opcode is 5 and slot 4 is active, `ar_incr` is high and the address register adds one, modulo 4096.
- R11: When none of `ar_load`, `ar_clear` or `ar_incr` is high, the address register holds its value.
- R12: At most one of `ar_load`, `ar_clear` and `ar_incr` is high in any cycle. If more than one were ever requested, clear would win over load, and load over increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_load | input | 1 | Capture `ir_data_in` into the instruction register |
| ir_data_in | input | 16 | Instruction word to capture |
| sc_clear | input | 1 | Return the sequence counter to slot 0 |
| intr_flag | input | 1 | Interrupt cycle flag |
| pc_in | input | 12 | Program counter value, a load source |
| mem_data_in | input | 12 | Memory read data, a load source |
| ir_q | output | 16 | Held instruction word |
| opcode_lines | output | 8 | One-hot decode of `ir_q[14:12]` |
| ind_bit | output | 1 | Indirect flag, `ir_q[15]` |
| time_lines | output | 16 | One-hot decode of the sequence counter |
| ar_load | output | 1 | Address register load control |
| ar_clear | output | 1 | Address register clear control |
| ar_incr | output | 1 | Address register increment control |
| ar_q | output | 12 | Address register contents |

## Verification
Every opcode is run with both indirect values and both interrupt values, and each combination walks all sixteen time slots. This separates the slot-0 load from the slot-0 clear, shows that opcode 7 blocks the slot-3 memory load, and shows that only opcode 5 gives a slot-4 increment. The program counter, memory data and instruction address fields use different values in every cycle, so a load from the wrong source gives a wrong address. An initial address of 12'hFFF makes the increment wrap. A counter clear mid-walk, and a long run with no clear, check the return to slot 0 and the wrap from 15 to 0.

// File: rtl/ctu_pkg.sv
// Package: shared widths and the address-register control bundle.
// Assumes a 3-bit opcode sitting directly below the indirect flag.
package ctu_pkg;
    localparam int OPC_W   = 3;
    localparam int OPC_LSB = 12;

    // Source select for an address-register load
    typedef enum logic [1:0] {
        SRC_PC  = 2'd0,
        SRC_IR  = 2'd1,
        SRC_MEM = 2'd2
    } ar_src_e;

    // Control bundle from the term logic to the register
    typedef struct packed {
        logic    ld;
        logic    clr;
        logic    inr;
        ar_src_e src;
    } ar_ctl_t;
endpackage

// File: rtl/ctu_onehot_dec.sv
// Module: binary to one-hot decoder, with a parameter for the input width.
// Assumes IN_W is small (output is 2**IN_W lines).
module ctu_onehot_dec #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]       code,
    output logic [(1<<IN_W)-1:0]  lines
);
    localparam int OUT_N = 1 << IN_W;

    // One comparator per output line
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign lines[k] = (code == k[IN_W-1:0]);
    end
endmodule

// File: rtl/ctu_seq_counter.sv
// Module: sequence counter for the time slots. Counts up and wraps,
// with a synchronous clear. Assumes an active-low synchronous reset.
module ctu_seq_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Step the slot count, or restart it at zero
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end
endmodule

// File: rtl/ctu_instr_reg.sv
// Module: instruction register with a load enable.
// Assumes an active-low synchronous reset to zero.
module ctu_instr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture a new instruction word when asked
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ctu_ar_ctrl.sv
// Module: sum-of-products terms for the address-register controls.
// Assumes one-hot opcode and slot lines; only the lines it needs come in.
module ctu_ar_ctrl
    import ctu_pkg::*;
(
    input  logic    op5,
    input  logic    op7,
    input  logic    ind,
    input  logic    intr,
    input  logic    t0,
    input  logic    t2,
    input  logic    t3,
    input  logic    t4,
    output ar_ctl_t ctl
);
    logic ld_pc, ld_ir, ld_mem;

    // Form the load, clear and increment terms and pick the load source
    always_comb begin
        ld_pc   = !intr & t0;
        ld_ir   = !intr & t2;
        ld_mem  = !op7 & ind & t3;
        ctl.ld  = ld_pc | ld_ir | ld_mem;
        ctl.clr = intr & t0;
        ctl.inr = op5 & t4;
        if (ld_pc)      ctl.src = SRC_PC;
        else if (ld_ir) ctl.src = SRC_IR;
        else            ctl.src = SRC_MEM;
    end
endmodule

// File: rtl/ctu_addr_reg.sv
// Module: address register. Priority is clear, then load, then increment.
// Assumes an active-low synchronous reset to zero.
module ctu_addr_reg
    import ctu_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ar_ctl_t      ctl,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] ir_addr,
    input  logic [W-1:0] mem,
    output logic [W-1:0] q
);
    logic [W-1:0] ld_val;

    // Select the load source
    always_comb begin
        case (ctl.src)
            SRC_PC:  ld_val = pc;
            SRC_IR:  ld_val = ir_addr;
            default: ld_val = mem;
        endcase
    end

    // Apply the controls in priority order
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (ctl.clr) q <= '0;
        else if (ctl.ld)  q <= ld_val;
        else if (ctl.inr) q <= q + 1'b1;
    end
endmodule

// File: rtl/ctl_timing_unit.sv
// Top: instruction register, opcode and slot decoders, sequence counter,
// address-register term logic and the address register.
// Assumes WORD_W = ADDR_W + OPC_W + 1 (the indirect flag is the top bit).
module ctl_timing_unit
    import ctu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ir_load,
    input  logic [WORD_W-1:0]    ir_data_in,
    input  logic                 sc_clear,
    input  logic                 intr_flag,
    input  logic [ADDR_W-1:0]    pc_in,
    input  logic [ADDR_W-1:0]    mem_data_in,
    output logic [WORD_W-1:0]    ir_q,
    output logic [(1<<OPC_W)-1:0] opcode_lines,
    output logic                 ind_bit,
    output logic [(1<<SC_W)-1:0] time_lines,
    output logic                 ar_load,
    output logic                 ar_clear,
    output logic                 ar_incr,
    output logic [ADDR_W-1:0]    ar_q
);
    localparam int IND_POS = WORD_W - 1;

    logic [SC_W-1:0] sc_count;
    ar_ctl_t         ar_ctl;

    ctu_instr_reg #(.W(WORD_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .load(ir_load), .d(ir_data_in), .q(ir_q)
    );

    ctu_onehot_dec #(.IN_W(OPC_W)) u_opdec (
        .code(ir_q[OPC_LSB +: OPC_W]), .lines(opcode_lines)
    );

    ctu_seq_counter #(.W(SC_W)) u_sc (
        .clk(clk), .rst_n(rst_n), .clr(sc_clear), .count(sc_count)
    );

    ctu_onehot_dec #(.IN_W(SC_W)) u_tdec (
        .code(sc_count), .lines(time_lines)
    );

    // Indirect flag straight from the instruction word
    assign ind_bit = ir_q[IND_POS];

    ctu_ar_ctrl u_terms (
        .op5(opcode_lines[5]), .op7(opcode_lines[7]), .ind(ind_bit),
        .intr(intr_flag), .t0(time_lines[0]), .t2(time_lines[2]),
        .t3(time_lines[3]), .t4(time_lines[4]), .ctl(ar_ctl)
    );

    ctu_addr_reg #(.W(ADDR_W)) u_ar (
        .clk(clk), .rst_n(rst_n), .ctl(ar_ctl), .pc(pc_in),
        .ir_addr(ir_q[ADDR_W-1:0]), .mem(mem_data_in), .q(ar_q)
    );

    // Bring the controls out to the ports
    assign ar_load  = ar_ctl.ld;
    assign ar_clear = ar_ctl.clr;
    assign ar_incr  = ar_ctl.inr;
endmodule

// File: rtl/ctu_checker.sv
// Checker: temporal properties of the control timing unit, bound to the top.
module ctu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ir_load,
    input logic [15:0] ir_data_in,
    input logic        sc_clear,
    input logic [15:0] ir_q,
    input logic [7:0]  opcode_lines,
    input logic [15:0] time_lines,
    input logic        ar_load,
    input logic        ar_clear,
    input logic        ar_incr,
    input logic [11:0] ar_q
);
    p_ctl_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ar_load, ar_clear, ar_incr}));

    p_slot_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(time_lines) == 1);

    p_opcode_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(opcode_lines) == 1);

    p_sc_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clear |=> time_lines[0]);

    p_ir_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> ir_q == $past(ir_data_in));

    p_ar_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ar_clear |=> ar_q == 12'd0);

    p_ar_incr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ar_incr |=> ar_q == $past(ar_q) + 12'd1);

    p_ar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_load || ar_clear || ar_incr) |=> $stable(ar_q));
endmodule

bind ctl_timing_unit ctu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_data_in(ir_data_in),
    .sc_clear(sc_clear), .ir_q(ir_q), .opcode_lines(opcode_lines),
    .time_lines(time_lines), .ar_load(ar_load), .ar_clear(ar_clear),
    .ar_incr(ar_incr), .ar_q(ar_q)
);

// File: tb/ctl_timing_unit_bench.sv
// Bench: behavioural reference model, compared every cycle at the falling edge.
module ctl_timing_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic [15:0] ir_data_in = '0;
    logic        sc_clear = 1'b0;
    logic        intr_flag = 1'b0;
    logic [11:0] pc_in = '0;
    logic [11:0] mem_data_in = '0;
    logic [15:0] ir_q;
    logic [7:0]  opcode_lines;
    logic        ind_bit;
    logic [15:0] time_lines;
    logic        ar_load, ar_clear, ar_incr;
    logic [11:0] ar_q;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference state
    int m_slot = 0;
    int m_ir = 0;
    int m_ar = 0;

    ctl_timing_unit u_ctl_timing_unit (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_data_in(ir_data_in),
        .sc_clear(sc_clear), .intr_flag(intr_flag), .pc_in(pc_in),
        .mem_data_in(mem_data_in), .ir_q(ir_q), .opcode_lines(opcode_lines),
        .ind_bit(ind_bit), .time_lines(time_lines), .ar_load(ar_load),
        .ar_clear(ar_clear), .ar_incr(ar_incr), .ar_q(ar_q)
    );

    always #10 clk = ~clk;

    function automatic int opc(); return (m_ir >> 12) & 7; endfunction
    function automatic int ind(); return (m_ir >> 15) & 1; endfunction
    function automatic bit e_ld();
        return (!intr_flag && (m_slot == 0 || m_slot == 2)) ||
               (opc() != 7 && ind() == 1 && m_slot == 3);
    endfunction
    function automatic bit e_clr(); return intr_flag && m_slot == 0; endfunction
    function automatic bit e_inr(); return opc() == 5 && m_slot == 4; endfunction

    // Reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot <= 0; m_ir <= 0; m_ar <= 0;
        end else begin
            if (e_clr())                      m_ar <= 0;
            else if (e_ld() && m_slot == 0)   m_ar <= int'(pc_in);
            else if (e_ld() && m_slot == 2)   m_ar <= m_ir & 12'hFFF;
            else if (e_ld())                  m_ar <= int'(mem_data_in);
            else if (e_inr())                 m_ar <= (m_ar + 1) % 4096;
            m_slot <= sc_clear ? 0 : (m_slot + 1) % 16;
            if (ir_load) m_ir <= int'(ir_data_in);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare every port with the model
    task automatic compare_all();
        chk("R2 ir_q", int'(ir_q), m_ir);
        chk("R3 opcode_lines", int'(opcode_lines), 1 << opc());
        chk("R3 ind_bit", int'(ind_bit), ind());
        chk("R4 time_lines", int'(time_lines), 1 << m_slot);
        chk("R6 R7 R8 ar_load", int'(ar_load), int'(e_ld()));
        chk("R9 ar_clear", int'(ar_clear), int'(e_clr()));
        chk("R10 ar_incr", int'(ar_incr), int'(e_inr()));
        chk("R12 exclusive", int'(ar_load) + int'(ar_clear) + int'(ar_incr) > 1 ? 1 : 0, 0);
        chk("R6 R7 R8 R9 R10 R11 ar_q", int'(ar_q), m_ar);
    endtask

    // One cycle: check outputs, then drive fresh address sources
    task automatic step(input int seed);
        @(negedge clk);
        compare_all();
        pc_in       = 12'((seed * 37 + 11) & 12'hFFF);
        mem_data_in = 12'((seed * 91 + 1234) & 12'hFFF);
        ir_load     = 1'b0;
        sc_clear    = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ir_q", int'(ir_q), 0);
        chk("R1 ar_q", int'(ar_q), 0);
        chk("R1 time_lines", int'(time_lines), 1);
        chk("R1 opcode_lines", int'(opcode_lines), 1);
        rst_n = 1'b1;

        // Sweep opcode x indirect x interrupt over all sixteen slots
        for (int op = 0; op < 8; op++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int rv = 0; rv < 2; rv++) begin
                    @(negedge clk);
                    compare_all();
                    ir_data_in = {iv[0], op[2:0], 12'((op * 300 + iv * 77 + rv * 5 + 9) & 12'hFFF)};
                    ir_load    = 1'b1;
                    sc_clear   = 1'b1;   // R5 restart with the new word
                    intr_flag  = rv[0];
                    for (int s = 0; s < 17; s++) step(op * 64 + iv * 32 + rv * 17 + s);
                end
            end
        end

        // R10 increment wrap: opcode 5, slot 2 loads 12'hFFF, slot 4 increments
        @(negedge clk);
        compare_all();
        ir_data_in = {1'b0, 3'd5, 12'hFFF};
        ir_load = 1'b1; sc_clear = 1'b1; intr_flag = 1'b0;
        for (int s = 0; s < 6; s++) step(s);
        chk("R10 wrap to zero", int'(ar_q), 0);

        // R5 mid-walk clear, R4 long free run over several wraps
        for (int s = 0; s < 3; s++) step(500 + s);
        @(negedge clk);
        compare_all();
        sc_clear = 1'b1;
        step(600);
        chk("R5 restart slot", int'(time_lines), 1);
        for (int s = 0; s < 40; s++) step(700 + s);

        // R2 hold: data changes without load
        @(negedge clk);
        ir_data_in = 16'hA5A5;
        for (int s = 0; s < 3; s++) step(800 + s);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ar_q after reset", int'(ar_q), 0);
        chk("R1 time_lines after reset", int'(time_lines), 1);
        chk("R1 ir_q after reset", int'(ir_q), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule